// File: doc/BRIEF.md
# Data Memory Overlay Address Decoder

This block sits between a processor's data-memory port and its memories. Each access carries a 14-bit word address, so the space holds 16K words of 16 bits. The block decides which target serves the access: the internal RAM, a small window of control registers, or one of two external overlay pages. The upper half of the space, 0x2000 to 0x3FFF, is always served on chip. Its top 32 words, 0x3FE0 to 0x3FFF, form the register window, and the rest of that half is RAM. A 2-bit overlay selector decides what the lower half, 0x0000 to 0x1FFF, reaches. Value 0 selects internal RAM. Values 1 and 2 select external page 0 and external page 1. Value 3 is reserved and behaves like 0.

Internal accesses finish in the cycle they are presented. An external access drives an active-low select and a 14-bit external address. The external address carries the 13 low address bits and uses its top line to mark the page. A programmable wait count stretches the external access. The block holds `ready` low for that many cycles, and the requester keeps its address and strobes steady until it sees `ready` high at a clock edge.

Top module: `dm_overlay_decoder`

## Requirements
- R1: With overlay 0 and a strobe active, an address in 0x0000–0x1FFF raises `ram_en`, keeps `ext_sel_n` high and keeps `ready` high.
- R2: With a strobe active, an address in 0x2000–0x3FDF raises `ram_en` and never asserts `ext_sel_n`, whatever the overlay value.
- R3: With a strobe active, an address in 0x3FE0–0x3FFF raises `reg_en`, keeps `ram_en` low and keeps `ext_sel_n` high, whatever the overlay value.
- R4: With overlay 1 or 2 and a strobe active, an address in 0x0000–0x1FFF drives `ext_sel_n` low and `ram_en` low. `ext_addr[12:0]` equals the address bits 12:0, and `ext_addr[13]` is 0 for overlay 1 and 1 for overlay 2.
- R5: Overlay value 3 treats 0x0000–0x1FFF as internal RAM: `ram_en` high and `ext_sel_n` high.
- R6: An external access presented with a wait count of N holds `ready` low for exactly N cycles, counted from its first cycle, and then raises it. With N = 0, `ready` is high in the first cycle. `ready` is never low unless `ext_sel_n` is low.
- R7: The wait count is sampled in the first cycle of an external access. Changing `dm_wait` later in the same access does not change the number of low `ready` cycles.
- R8: With neither `dm_rd` nor `dm_wr` active, `ram_en` and `reg_en` are low, and `ext_sel_n` and `ready` are high.
- R9: During and directly after reset, `ready` is high and no enable or select is active while no strobe is present.
- R10: `ext_addr` is all zeros whenever `ext_sel_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dm_addr | input | 14 | Word address of the access |
| dm_rd | input | 1 | Read strobe |
| dm_wr | input | 1 | Write strobe |
| ovl_sel | input | 2 | Overlay selector for the lower half (0 internal, 1 page 0, 2 page 1, 3 internal) |
| dm_wait | input | 3 | Wait states applied to an external access |
| ram_en | output | 1 | Internal RAM enable |
| reg_en | output | 1 | Register window enable |
| ext_sel_n | output | 1 | Active-low external data-memory select |
| ext_addr | output | 14 | External address: page bit on top, 13 low address bits below |
| ready | output | 1 | Access completes at the next clock edge when high |

## Verification
A wrong decode shows at the ports in the same cycle the address is presented. It appears as the wrong enable, a stray select, or a page bit that does not match the overlay. A fault in the wait counter shows up only at the end of an external access. It appears as a `ready` that rises one cycle early or late, or as an access that never completes. The bench therefore counts the low `ready` cycles of every external access for several wait counts, including zero and the maximum. It also changes `dm_wait` in the middle of an access, to expose a counter that reloads instead of holding its sampled value.

// File: rtl/dm_ovl_pkg.sv
package dm_ovl_pkg;
   typedef enum logic [1:0] {
      RGN_IDLE = 2'd0,
      RGN_RAM  = 2'd1,
      RGN_REG  = 2'd2,
      RGN_EXT  = 2'd3
   } dm_rgn_e;
endpackage

// File: rtl/dm_ovl_region.sv
module dm_ovl_region
   import dm_ovl_pkg::*;
#(
   parameter int ADDR_W    = 14,
   parameter int OVL_W     = 2,
   parameter int REG_WORDS = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              acc,
   input  logic [OVL_W-1:0]  ovl,
   output dm_rgn_e           rgn,
   output logic              page_hi
);
   localparam int                HALF_BIT  = ADDR_W - 1;
   localparam logic [OVL_W-1:0]  OVL_PG0   = OVL_W'(1);
   localparam logic [OVL_W-1:0]  OVL_PG1   = OVL_W'(2);
   localparam logic [ADDR_W-1:0] REG_BASE  = ADDR_W'((1 << ADDR_W) - REG_WORDS);

   logic in_regs;
   logic ovl_ext;

   generate
      if (REG_WORDS > 0) begin : g_regwin
         assign in_regs = (addr >= REG_BASE);
      end else begin : g_noregwin
         assign in_regs = 1'b0;
      end
   endgenerate

   assign ovl_ext = (ovl == OVL_PG0) || (ovl == OVL_PG1);
   assign page_hi = (ovl == OVL_PG1);

   always_comb begin
      if (!acc)                        rgn = RGN_IDLE;
      else if (addr[HALF_BIT]) begin
         if (in_regs)                  rgn = RGN_REG;
         else                          rgn = RGN_RAM;
      end else if (ovl_ext)            rgn = RGN_EXT;
      else                             rgn = RGN_RAM;
   end
endmodule

// File: rtl/dm_wait_timer.sv
module dm_wait_timer #(
   parameter int WAIT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_req,
   input  logic [WAIT_W-1:0] wait_in,
   output logic              ready
);
   localparam logic [WAIT_W-1:0] ZERO = '0;
   localparam logic [WAIT_W-1:0] ONE  = WAIT_W'(1);

   logic              busy_q;
   logic [WAIT_W-1:0] cnt_q;

   always_comb begin
      if (!ext_req)     ready = 1'b1;
      else if (busy_q)  ready = (cnt_q == ZERO);
      else              ready = (wait_in == ZERO);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= ZERO;
      end else if (!ext_req) begin
         busy_q <= 1'b0;
      end else if (!busy_q) begin
         if (wait_in != ZERO) begin
            busy_q <= 1'b1;
            cnt_q  <= wait_in - ONE;
         end
      end else if (cnt_q == ZERO) begin
         busy_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q - ONE;
      end
   end
endmodule

// File: rtl/dm_overlay_decoder.sv
module dm_overlay_decoder
   import dm_ovl_pkg::*;
#(
   parameter int ADDR_W    = 14,
   parameter int OVL_W     = 2,
   parameter int WAIT_W    = 3,
   parameter int REG_WORDS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] dm_addr,
   input  logic              dm_rd,
   input  logic              dm_wr,
   input  logic [OVL_W-1:0]  ovl_sel,
   input  logic [WAIT_W-1:0] dm_wait,
   output logic              ram_en,
   output logic              reg_en,
   output logic              ext_sel_n,
   output logic [ADDR_W-1:0] ext_addr,
   output logic              ready
);
   localparam int PAGE_W = ADDR_W - 1;

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("dm_overlay_decoder: ADDR_W too small");
      end
      if (OVL_W < 2) begin : g_bad_ovl
         $error("dm_overlay_decoder: OVL_W must hold values up to 2");
      end
      if (WAIT_W < 1) begin : g_bad_wait
         $error("dm_overlay_decoder: WAIT_W must be at least 1");
      end
      if (REG_WORDS < 0 || REG_WORDS > (1 << (ADDR_W - 1)) ||
          (REG_WORDS & (REG_WORDS - 1)) != 0) begin : g_bad_regs
         $error("dm_overlay_decoder: REG_WORDS must be a power of two within the upper half");
      end
   endgenerate

   dm_rgn_e rgn;
   logic    page_hi;
   logic    ext_req;

   dm_ovl_region #(
      .ADDR_W    (ADDR_W),
      .OVL_W     (OVL_W),
      .REG_WORDS (REG_WORDS)
   ) u_region (
      .addr    (dm_addr),
      .acc     (dm_rd | dm_wr),
      .ovl     (ovl_sel),
      .rgn     (rgn),
      .page_hi (page_hi)
   );

   assign ext_req = (rgn == RGN_EXT);

   dm_wait_timer #(
      .WAIT_W (WAIT_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .ext_req (ext_req),
      .wait_in (dm_wait),
      .ready   (ready)
   );

   assign ram_en    = (rgn == RGN_RAM);
   assign reg_en    = (rgn == RGN_REG);
   assign ext_sel_n = ~ext_req;
   assign ext_addr  = ext_req ? {page_hi, dm_addr[PAGE_W-1:0]} : '0;
endmodule

// File: rtl/dm_overlay_decoder_chk.sv
module dm_overlay_decoder_chk #(
   parameter int ADDR_W    = 14,
   parameter int OVL_W     = 2,
   parameter int WAIT_W    = 3,
   parameter int REG_WORDS = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] dm_addr,
   input logic              dm_rd,
   input logic              dm_wr,
   input logic [OVL_W-1:0]  ovl_sel,
   input logic [WAIT_W-1:0] dm_wait,
   input logic              ram_en,
   input logic              reg_en,
   input logic              ext_sel_n,
   input logic [ADDR_W-1:0] ext_addr,
   input logic              ready
);
   localparam logic [ADDR_W-1:0] REG_BASE = ADDR_W'((1 << ADDR_W) - REG_WORDS);
   localparam logic [OVL_W-1:0]  OVL_PG1  = OVL_W'(2);
   localparam logic [OVL_W-1:0]  OVL_RSV  = OVL_W'(3);

   logic [WAIT_W:0]   run_q;
   logic [WAIT_W-1:0] n_q;
   logic              acc;

   assign acc = dm_rd | dm_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         n_q   <= '0;
      end else if (!ready) begin
         if (run_q == '0) n_q <= dm_wait;
         if (run_q != {1'b1, {WAIT_W{1'b0}}}) run_q <= run_q + 1'b1;
      end else begin
         run_q <= '0;
      end
   end

   assert_upper_ram_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && dm_addr[ADDR_W-1] && dm_addr < REG_BASE) |-> (ram_en && ext_sel_n));

   assert_reg_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_en |-> (!ram_en && ext_sel_n && dm_addr >= REG_BASE));

   assert_page_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_sel_n |-> (ext_addr == {ovl_sel == OVL_PG1, dm_addr[ADDR_W-2:0]} && !ram_en));

   assert_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovl_sel == OVL_RSV) |-> ext_sel_n);

   assert_stall_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !ext_sel_n);

   assert_wait_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !ext_sel_n && run_q != '0) |-> (run_q == {1'b0, n_q}));

   assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |-> (ext_sel_n && !ram_en && !reg_en && ready));

   assert_addr_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ext_sel_n |-> (ext_addr == '0));
endmodule

bind dm_overlay_decoder dm_overlay_decoder_chk #(
   .ADDR_W    (ADDR_W),
   .OVL_W     (OVL_W),
   .WAIT_W    (WAIT_W),
   .REG_WORDS (REG_WORDS)
) u_chk (.*);

// File: tb/sim_dm_overlay_decoder.sv
module sim_dm_overlay_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] dm_addr = '0;
   logic        dm_rd = 1'b0;
   logic        dm_wr = 1'b0;
   logic [1:0]  ovl_sel = '0;
   logic [2:0]  dm_wait = '0;
   logic        ram_en, reg_en, ext_sel_n, ready;
   logic [13:0] ext_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dm_overlay_decoder u0 (
      .clk(clk), .rst_n(rst_n), .dm_addr(dm_addr), .dm_rd(dm_rd), .dm_wr(dm_wr),
      .ovl_sel(ovl_sel), .dm_wait(dm_wait), .ram_en(ram_en), .reg_en(reg_en),
      .ext_sel_n(ext_sel_n), .ext_addr(ext_addr), .ready(ready)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // outputs packed as {ram_en, reg_en, ext_sel_n, ready}
   function automatic logic [3:0] outs();
      return {ram_en, reg_en, ext_sel_n, ready};
   endfunction

   task automatic idle_bus();
      @(negedge clk);
      dm_rd = 1'b0; dm_wr = 1'b0;
   endtask

   task automatic internal_acc(input string req, input logic [13:0] a, input logic [1:0] ov,
                               input logic wr, input logic [3:0] exp);
      @(negedge clk);
      dm_addr = a; ovl_sel = ov; dm_rd = ~wr; dm_wr = wr; dm_wait = 3'd7;
      #1;
      check(req, {28'd0, outs()}, {28'd0, exp});
      check({req, " ext_addr"}, {18'd0, ext_addr}, 32'd0);
      idle_bus();
   endtask

   task automatic ext_acc(input string req, input logic [13:0] a, input logic [1:0] ov,
                          input logic [2:0] n, input bit poke_wait);
      int lows = 0;
      @(negedge clk);
      dm_addr = a; ovl_sel = ov; dm_rd = 1'b1; dm_wr = 1'b0; dm_wait = n;
      #1;
      check({req, " select"}, {28'd0, outs()}, {28'd0, 2'b00, 1'b0, n == 3'd0});
      check({req, " ext_addr"}, {18'd0, ext_addr}, {18'd0, ov == 2'd2, a[12:0]});
      while (!ready && lows < 20) begin
         lows++;
         if (!ext_sel_n) checks++; else begin
            checks++; errors++;
            $display("FAIL %s: ext_sel_n actual 1 expected 0 during stall", req);
         end
         @(negedge clk);
         if (poke_wait) dm_wait = 3'd1;
         #1;
      end
      check({req, " wait cycles"}, lows, {29'd0, n});
      idle_bus();
   endtask

   task automatic test_reset();
      #1;
      check("R9 in reset", {28'd0, outs()}, 32'b0011);
      @(negedge clk); rst_n = 1'b1;
      #1;
      check("R9 after reset", {28'd0, outs()}, 32'b0011);
   endtask

   task automatic test_idle();
      @(negedge clk);
      dm_addr = 14'h0123; ovl_sel = 2'd1; dm_rd = 1'b0; dm_wr = 1'b0;
      #1;
      check("R8 no strobe ext page", {28'd0, outs()}, 32'b0011);
      check("R10 no strobe addr", {18'd0, ext_addr}, 32'd0);
      dm_addr = 14'h3FF0;
      #1;
      check("R8 no strobe regs", {28'd0, outs()}, 32'b0011);
   endtask

   initial begin
      test_reset();
      test_idle();
      internal_acc("R1 ovl0 low", 14'h0000, 2'd0, 1'b0, 4'b1011);
      internal_acc("R1 ovl0 top of low", 14'h1FFF, 2'd0, 1'b1, 4'b1011);
      internal_acc("R2 upper ovl1", 14'h2000, 2'd1, 1'b0, 4'b1011);
      internal_acc("R2 upper ovl2", 14'h3FDF, 2'd2, 1'b1, 4'b1011);
      internal_acc("R3 regs base ovl0", 14'h3FE0, 2'd0, 1'b0, 4'b0111);
      internal_acc("R3 regs top ovl2", 14'h3FFF, 2'd2, 1'b1, 4'b0111);
      internal_acc("R5 ovl3 low", 14'h0ABC, 2'd3, 1'b0, 4'b1011);
      ext_acc("R4 R6 page0 n0", 14'h1555, 2'd1, 3'd0, 1'b0);
      ext_acc("R4 R6 page1 n1", 14'h0AAA, 2'd2, 3'd1, 1'b0);
      ext_acc("R6 page0 n3", 14'h1FFF, 2'd1, 3'd3, 1'b0);
      ext_acc("R6 page1 n7", 14'h0001, 2'd2, 3'd7, 1'b0);
      ext_acc("R7 wait change mid access", 14'h0777, 2'd1, 3'd5, 1'b1);
      ext_acc("R6 back to back", 14'h0010, 2'd2, 3'd2, 1'b0);
      internal_acc("R10 after ext", 14'h2345, 2'd2, 1'b0, 4'b1011);
      done = 1'b1;
   end

   initial begin
      for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule